// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block receives serial data one byte at a time, with a shared transfer clock and a single data line. It runs either as clock master or as clock slave. As master it makes the transfer clock from the system clock through a programmable power-of-two divider, drives it onto the clock pin and keeps clocking bytes in back to back. As slave it watches a clock that arrives from outside. Data is sampled on each rising clock edge, least significant bit first, eight edges to a byte.

When a byte is complete the shift register contents move into a receive holding register and a data-ready flag rises. Software reads the holding register to take the byte, which clears the flag. If another byte completes while the flag is still set, an overrun flag rises and the held byte is kept. A stop-after-byte control lets the master finish the byte in progress and then hold the clock high.

The control loop is a four-state machine. `ST_OFF` is the disabled state. `ST_SLAVE` follows the external clock. `ST_MRUN` generates the clock. `ST_MPARK` drives the clock high and idle. The transitions are: enable with master set goes `ST_OFF`→`ST_MRUN`, and enable with master clear goes `ST_OFF`→`ST_SLAVE`. Clearing enable returns any state to `ST_OFF`. Setting master moves `ST_SLAVE`→`ST_MRUN`, and clearing master moves either master state to `ST_SLAVE`. A byte completing while stop is set moves `ST_MRUN`→`ST_MPARK`, and clearing stop moves `ST_MPARK`→`ST_MRUN`.

Top module: `csync_rx`

## Requirements
- R1: After reset the status reads 0, the clock output enable is 0 and the clock output is 1.
- R2: The clock output enable is 1 when the block is enabled and control bit 1 (master) is 1. It is 0 whenever master is 0.
- R3: In master mode the clock-select field n (control bits 7:4) gives a transfer clock period of 2^(n+1) system clocks. The clock idles high and is first pulled low after enabling.
- R4: Data is sampled on rising transfer-clock edges, least significant bit first. On the 8th edge the byte is copied to the data register (address 2) and status bit 0 (full) is set.
- R5: In master mode with stop clear, the clock runs without a gap between bytes, so consecutive bytes are received back to back.
- R6: Reading address 2 clears status bit 0.
- R7: If the 8th edge of a byte occurs while full is 1 and the data register is not being read, status bit 1 (overrun) is set and the data register keeps its previous byte.
- R8: Writing status (address 1) with bit 1 equal to 0 clears overrun only after status has been read with overrun at 1. Before that read, the write has no effect.
- R9: With control bit 2 (stop) set in master mode, clocking stops when the byte in progress completes. The clock output then stays high with no further rising edges.
- R10: With master clear, the external clock and data go through a two-flop synchroniser, and each synchronised rising edge shifts in one bit. The external clock may run up to one quarter of the system clock.
- R11: Clearing control bit 0 (enable) clears the bit counter and shift register and leaves full, overrun and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 1 and 2) |
| reg_addr | input | 2 | 0 control, 1 status, 2 receive data |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for the addressed register |
| sck_i | input | 1 | External transfer clock (slave mode) |
| sck_o | output | 1 | Generated transfer clock, high when idle |
| sck_oe | output | 1 | Clock pin drive enable |
| sd_i | input | 1 | Serial data input |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 4-bit clock-select field. At run time it sets clock-select values 0, 1 and 2, which gives transfer periods of 2, 4 and 8 system clocks. The period is measured directly at divide-by-2 and divide-by-8. The divide-by-4 rate leaves room to let several bytes pass unread, which exposes overrun retention and the armed clear of the overrun flag. In slave mode the bench drives an 8-cycle external clock, which is twice the minimum period.

// File: rtl/csync_pkg.sv
package csync_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SLAVE = 2'd1,
        ST_MRUN  = 2'd2,
        ST_MPARK = 2'd3
    } rx_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTL_EN   = 0;
    localparam int CTL_MST  = 1;
    localparam int CTL_STOP = 2;
    localparam int CTL_SEL  = 4;

    localparam int STS_FULL = 0;
    localparam int STS_OVR  = 1;
endpackage

// File: rtl/csync_clkgen.sv
module csync_clkgen #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sck_o,
    output logic             rise_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   limit;
    logic             sck_q;
    logic             tick;

    always_comb begin
        span  = (CNT_W + 1)'(1) << sel_i;
        limit = span - (CNT_W + 1)'(1);
        tick  = run_i && (cnt == limit[CNT_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (!run_i) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            cnt   <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign rise_o = tick & ~sck_q;
    assign sck_o  = sck_q | ~run_i;
endmodule

// File: rtl/csync_sync.sv
module csync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sd_i,
    output logic rise_o,
    output logic sd_o
);
    logic [STAGES-1:0] sck_sh;
    logic [STAGES-1:0] sd_sh;
    logic              sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh   <= '1;
            sd_sh    <= '0;
            sck_last <= 1'b1;
        end else begin
            sck_sh   <= {sck_sh[STAGES-2:0], sck_i};
            sd_sh    <= {sd_sh[STAGES-2:0], sd_i};
            sck_last <= sck_sh[STAGES-1];
        end
    end

    assign rise_o = sck_sh[STAGES-1] & ~sck_last;
    assign sd_o   = sd_sh[STAGES-1];
endmodule

// File: rtl/csync_shift.sv
module csync_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rise_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              last;

    assign last   = (cnt == CNT_W'(DATA_W - 1));
    assign done_o = rise_i & last;
    assign byte_o = {bit_i, sh[DATA_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clr_i) begin
            sh  <= '0;
            cnt <= '0;
        end else if (rise_i) begin
            sh  <= {bit_i, sh[DATA_W-1:1]};
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csync_rx.sv
module csync_rx #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4,
    localparam int REG_W = (DATA_W > SEL_W + 4) ? DATA_W : SEL_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sd_i
);
    import csync_pkg::*;

    rx_state_e         state, nstate;
    logic              ctl_en, ctl_mst, ctl_stop;
    logic [SEL_W-1:0]  ctl_sel;
    logic              full, ovr, arm;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] byte_in;
    logic              gen_run, use_ext, shift_clr;
    logic              g_rise, s_rise, s_sd;
    logic              rise, bit_in, done;
    logic              rd_data, rd_stat, ovr_clr, full_eff;

    csync_clkgen #(.SEL_W(SEL_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .run_i(gen_run), .sel_i(ctl_sel),
        .sck_o(sck_o), .rise_o(g_rise)
    );

    csync_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sd_i(sd_i),
        .rise_o(s_rise), .sd_o(s_sd)
    );

    csync_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(shift_clr), .rise_i(rise),
        .bit_i(bit_in), .done_o(done), .byte_o(byte_in)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF:   if (ctl_en) nstate = ctl_mst ? ST_MRUN : ST_SLAVE;
            ST_SLAVE: if (!ctl_en) nstate = ST_OFF;
                      else if (ctl_mst) nstate = ST_MRUN;
            ST_MRUN:  if (!ctl_en) nstate = ST_OFF;
                      else if (!ctl_mst) nstate = ST_SLAVE;
                      else if (done && ctl_stop) nstate = ST_MPARK;
            ST_MPARK: if (!ctl_en) nstate = ST_OFF;
                      else if (!ctl_mst) nstate = ST_SLAVE;
                      else if (!ctl_stop) nstate = ST_MRUN;
            default:  nstate = ST_OFF;
        endcase
    end

    // per-state outputs
    always_comb begin
        gen_run   = 1'b0;
        use_ext   = 1'b0;
        shift_clr = 1'b0;
        sck_oe    = 1'b0;
        unique case (state)
            ST_OFF:   shift_clr = 1'b1;
            ST_SLAVE: use_ext   = 1'b1;
            ST_MRUN:  begin gen_run = 1'b1; sck_oe = 1'b1; end
            ST_MPARK: sck_oe    = 1'b1;
            default:  shift_clr = 1'b1;
        endcase
    end

    assign rise     = gen_run ? g_rise : (use_ext & s_rise);
    assign bit_in   = gen_run ? sd_i : s_sd;
    assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
    assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
    assign ovr_clr  = reg_wr && (reg_addr == ADDR_STAT) && !reg_wdata[STS_OVR] && arm;
    assign full_eff = full & ~rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mst  <= 1'b0;
            ctl_stop <= 1'b0;
            ctl_sel  <= '0;
        end else if (reg_wr && reg_addr == ADDR_CTRL) begin
            ctl_en   <= reg_wdata[CTL_EN];
            ctl_mst  <= reg_wdata[CTL_MST];
            ctl_stop <= reg_wdata[CTL_STOP];
            ctl_sel  <= reg_wdata[CTL_SEL +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            ovr     <= 1'b0;
            arm     <= 1'b0;
            rx_data <= '0;
        end else begin
            if (done && !full_eff) begin
                rx_data <= byte_in;
                full    <= 1'b1;
            end else if (rd_data) begin
                full    <= 1'b0;
            end
            if (done && full_eff) ovr <= 1'b1;
            else if (ovr_clr)     ovr <= 1'b0;
            if (ovr_clr)              arm <= 1'b0;
            else if (rd_stat && ovr)  arm <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_EN]            = ctl_en;
                reg_rdata[CTL_MST]           = ctl_mst;
                reg_rdata[CTL_STOP]          = ctl_stop;
                reg_rdata[CTL_SEL +: SEL_W]  = ctl_sel;
            end
            ADDR_STAT: begin
                reg_rdata[STS_FULL] = full;
                reg_rdata[STS_OVR]  = ovr;
            end
            ADDR_DATA: reg_rdata[DATA_W-1:0] = rx_data;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/csync_rx_chk.sv
module csync_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input csync_pkg::rx_state_e state,
    input logic                 rise,
    input logic                 done,
    input logic                 full,
    input logic                 ovr,
    input logic                 ovr_clr,
    input logic                 rd_data,
    input logic                 ctl_mst,
    input logic                 sck_o,
    input logic                 sck_oe,
    input logic [DATA_W-1:0]    rx_data,
    input logic [DATA_W-1:0]    byte_in
);
    import csync_pkg::*;

    assert_slave_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_mst |=> !sck_oe);

    assert_byte_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !full) |=> (full && rx_data == $past(byte_in)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !full);

    assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd_data) |=> (ovr && $stable(rx_data)));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    assert_park_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MPARK) |-> (!rise && sck_o));
endmodule

bind csync_rx csync_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .rise(rise), .done(done),
    .full(full), .ovr(ovr), .ovr_clr(ovr_clr), .rd_data(rd_data),
    .ctl_mst(ctl_mst), .sck_o(sck_o), .sck_oe(sck_oe),
    .rx_data(rx_data), .byte_in(byte_in)
);

// File: tb/tb_csync_rx.sv
`timescale 1ns/1ps
module tb_csync_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck_i = 1'b1, sd_i = 1'b0;
    logic       sck_o, sck_oe;

    int nchk = 0, nerr = 0;
    int mbit = 0, edges = 0;
    logic [7:0] mstream [8];

    csync_rx dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i)
    );

    always #5 clk = ~clk;

    // master-mode data feed: next bit presented on each falling clock
    always @(negedge sck_o) if (sck_oe) begin
        sd_i = mstream[(mbit / 8) % 8][mbit % 8];
        mbit++;
    end

    always @(posedge sck_o) if (sck_oe) edges++;

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_full();
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(2'd1, v);
            if (v[0]) return;
        end
    endtask

    task automatic load(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
        mstream[0] = b0; mstream[1] = b1; mstream[2] = b2; mstream[3] = b3;
        for (int i = 4; i < 8; i++) mstream[i] = 8'h00;
        mbit = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd1, v);
        check("R1 status", v, 0);
        check("R1 sck_oe", sck_oe, 0);
        check("R1 sck_o", sck_o, 1);
    endtask

    task automatic t_master_single();
        logic [7:0] v;
        time t0, t1;
        load(8'hA5, 8'h00, 8'h00, 8'h00);
        edges = 0;
        wr(2'd0, 8'h07);                       // en|mst|stop, sel 0
        @(posedge sck_o); t0 = $time;
        @(posedge sck_o); t1 = $time;
        check("R3 period div2", int'(t1 - t0), 20);
        wait_full();
        rd(2'd2, v);
        check("R4 byte a5", v, 8'hA5);
        repeat (40) @(negedge clk);
        check("R9 edge count", edges, 8);
        check("R9 parked high", sck_o, 1);
        check("R2 master drives", sck_oe, 1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_period_div8();
        logic [7:0] v;
        time t0, t1;
        load(8'h96, 8'h00, 8'h00, 8'h00);
        wr(2'd0, 8'h27);                       // en|mst|stop, sel 2
        @(posedge sck_o); t0 = $time;
        @(posedge sck_o); t1 = $time;
        check("R3 period div8", int'(t1 - t0), 80);
        wait_full();
        rd(2'd2, v);
        check("R4 byte 96", v, 8'h96);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_continuous();
        logic [7:0] v;
        load(8'h3C, 8'h81, 8'h5E, 8'hC7);
        wr(2'd0, 8'h13);                       // en|mst, sel 1
        wait_full();
        rd(2'd2, v);
        check("R5 first byte", v, 8'h3C);
        rd(2'd1, v);
        check("R6 full cleared", v[0], 0);
        wait_full();
        rd(2'd2, v);
        check("R5 second byte", v, 8'h81);
        repeat (100) @(negedge clk);
        wr(2'd0, 8'h17);                       // request stop
        repeat (40) @(negedge clk);
        wr(2'd1, 8'h00);                       // clear attempt, not armed
        rd(2'd1, v);
        check("R8 unarmed write ignored", v, 8'h03);
        wr(2'd1, 8'h00);
        rd(2'd1, v);
        check("R8 armed clear", v, 8'h01);
        rd(2'd2, v);
        check("R7 old byte kept", v, 8'h5E);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        load(8'h6B, 8'hFF, 8'hFF, 8'hFF);
        wr(2'd0, 8'h17);
        wait_full();
        wr(2'd0, 8'h13);                       // resume, partial byte
        repeat (3) @(posedge sck_o);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check("R11 flags kept", v, 8'h01);
        rd(2'd2, v);
        check("R11 data kept", v, 8'h6B);
        load(8'hD2, 8'h00, 8'h00, 8'h00);
        wr(2'd0, 8'h17);
        wait_full();
        rd(2'd2, v);
        check("R11 counter restarted", v, 8'hD2);
        wr(2'd0, 8'h00);
    endtask

    task automatic slave_byte(logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_i = 1'b0; sd_i = b[i];
            repeat (4) @(negedge clk);
            sck_i = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_slave();
        logic [7:0] v;
        wr(2'd0, 8'h01);                       // en, slave
        repeat (2) @(negedge clk);
        check("R2 slave no drive", sck_oe, 0);
        slave_byte(8'h4D);
        repeat (6) @(negedge clk);
        rd(2'd1, v);
        check("R10 full set", v, 8'h01);
        rd(2'd2, v);
        check("R10 slave byte 4d", v, 8'h4D);
        slave_byte(8'hB1);
        repeat (6) @(negedge clk);
        rd(2'd2, v);
        check("R10 slave byte b1", v, 8'hB1);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        #2_000_000;
        nerr++; nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        load(8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_master_single();
        t_period_div8();
        t_continuous();
        t_disable();
        t_slave();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule